// File: doc/BRIEF.md
# Memory String Compare Engine

This block carries out one compare of two operands that both live in memory. The first operand is read at a source pointer and the second at a destination pointer. The second is subtracted from the first, and the difference itself is thrown away. From it come six status flags: carry, parity, half-carry, zero, sign and overflow. After each compare both pointers move together by the operand size (1, 2 or 4 bytes), upward or downward according to a direction input. Operands are fetched one at a time over a single-port memory interface. The request side and the response side each use a valid/ready style handshake.

A pulse on `start` in idle launches the operation. The opcode picks a byte compare or a wide compare, and for the wide compare a size input picks word or doubleword. Two more inputs pick a 16-bit or 32-bit address size and, optionally, a repeat mode. In repeat mode the compare runs once for every unit of a count register. A one-cycle `done` marks the end of the whole operation, and in that cycle the updated pointers, the count and the flags are valid.

Top module: `mscmp_top`

## Requirements
- R1: `opcode` 8'hA6 selects a byte compare. 8'hA7 selects a word compare when `size32`=0 and a doubleword compare when `size32`=1. A start with any other opcode is ignored: `busy` stays 0, no memory request is issued, no `done` follows, and `si_out`, `di_out`, `cnt_out` and `flags_out` keep their values.
- R2: Each compare issues exactly two reads. The first is at the source pointer and the second at the destination pointer. `mem_req_size` is 0 for byte, 1 for word and 2 for doubleword. The operand is taken from the low bytes of `mem_rsp_data`.
- R3: `flags_out` holds {OF,SF,ZF,AF,PF,CF} in bits 5..0, computed from first minus second at the operand width. CF is the unsigned borrow. OF is signed overflow. SF is the top result bit. ZF is set when the result is zero.
- R4: AF is the borrow out of bit 3, that is, the low nibble of the first operand is below the low nibble of the second. PF is 1 when the low 8 result bits have an even number of ones.
- R5: With `dir`=0 both pointers increase by the step after each compare. With `dir`=1 both decrease. The step is 1, 2 or 4 for byte, word or doubleword.
- R6: With `addr32`=0 only the low 16 bits of each pointer are used and updated, and they wrap modulo 2^16. The upper 16 bits of the pointers are preserved, and the request addresses carry zero in bits 31..16. With `addr32`=1 all 32 bits are used.
- R7: A request holds `mem_req_valid` and a stable `mem_req_addr` until `mem_req_ready`. Only one read is outstanding at a time, and the engine waits for each response before it goes on.
- R8: With `rep_en`=1 and `cnt_in`=N>0, N compares run back to back with the pointers stepping each time. `cnt_out` is 0 at `done`, and the flags are those of the last compare. With `rep_en`=0 exactly one compare runs and `cnt_out` equals `cnt_in`.
- R9: With `rep_en`=1 and `cnt_in`=0, no memory request is issued. `done` still pulses, the pointers equal the inputs, `cnt_out` is 0 and `flags_out` is unchanged.
- R10: `busy` is high from the cycle after an accepted start until the cycle of `done`, which is high for exactly one cycle. No request is issued while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation (sampled in idle) |
| opcode | input | 8 | 8'hA6 byte compare, 8'hA7 wide compare |
| size32 | input | 1 | Wide compare size: 0 word, 1 doubleword |
| addr32 | input | 1 | Address size: 0 16-bit, 1 32-bit |
| dir | input | 1 | Pointer direction: 0 up, 1 down |
| rep_en | input | 1 | Repeat under the count |
| si_in | input | 32 | Source pointer at start |
| di_in | input | 32 | Destination pointer at start |
| cnt_in | input | 32 | Repeat count at start |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Read byte address |
| mem_req_size | output | 2 | 0 byte, 1 word, 2 doubleword |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data, little-endian, operand in low bytes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| si_out | output | 32 | Updated source pointer |
| di_out | output | 32 | Updated destination pointer |
| cnt_out | output | 32 | Updated count |
| flags_out | output | 6 | {OF,SF,ZF,AF,PF,CF} |

## Verification
The hardest situations to reach are 16-bit pointer wrap, in both directions, while the upper pointer half must survive, and a repeat run whose count is zero, which must leave the old flags in place. Directed cases put pointers at 0xFFFF and 0x0000 in short address mode. They also run a zero-count repeat right after a compare that left a known flag pattern. Signed-overflow, borrow and equal-operand cases are set up by writing chosen bytes into the bench memory. The memory model withholds ready and delays responses at random, so back-pressure reaches every request and wait state.

// File: rtl/mscmp_pkg.sv
`timescale 1ns/1ps
package mscmp_pkg;

    localparam logic [7:0] OPC_BYTE = 8'hA6;
    localparam logic [7:0] OPC_WIDE = 8'hA7;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } opsz_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD1,
        ST_WT1,
        ST_RD2,
        ST_WT2,
        ST_EXEC,
        ST_FIN
    } state_e;

    // bit 5 .. bit 0
    typedef struct packed {
        logic of_f;
        logic sf_f;
        logic zf_f;
        logic af_f;
        logic pf_f;
        logic cf_f;
    } flags_t;

    function automatic logic [2:0] step_of(opsz_e sz);
        case (sz)
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [31:0] width_mask(opsz_e sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_WORD: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic even_par(logic [7:0] v);
        return ~^v;
    endfunction

endpackage

// File: rtl/mscmp_alu.sv
`timescale 1ns/1ps
module mscmp_alu
    import mscmp_pkg::*;
(
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    input  opsz_e       sz,
    output flags_t      flags
);
    logic [31:0] msk, am, bm, res;
    logic        sa, sb, sr;

    always_comb begin
        msk = width_mask(sz);
        am  = op_a & msk;
        bm  = op_b & msk;
        res = (am - bm) & msk;
        case (sz)
            SZ_BYTE: begin sa = am[7];  sb = bm[7];  sr = res[7];  end
            SZ_WORD: begin sa = am[15]; sb = bm[15]; sr = res[15]; end
            default: begin sa = am[31]; sb = bm[31]; sr = res[31]; end
        endcase
        flags.cf_f = (am < bm);
        flags.of_f = (sa ^ sb) & (sr ^ sa);
        flags.sf_f = sr;
        flags.zf_f = (res == 32'd0);
        flags.af_f = (am[3:0] < bm[3:0]);
        flags.pf_f = even_par(res[7:0]);
    end
endmodule

// File: rtl/mscmp_step.sv
`timescale 1ns/1ps
module mscmp_step
    import mscmp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] ptr,
    input  opsz_e             sz,
    input  logic              down,
    input  logic              wide,
    output logic [ADDR_W-1:0] nxt
);
    localparam int SHORT_W = 16;

    logic [ADDR_W-1:0] amt, moved;

    always_comb begin
        amt   = ADDR_W'(step_of(sz));
        moved = down ? (ptr - amt) : (ptr + amt);
        nxt   = wide ? moved : {ptr[ADDR_W-1:SHORT_W], moved[SHORT_W-1:0]};
    end
endmodule

// File: rtl/mscmp_fsm.sv
`timescale 1ns/1ps
module mscmp_fsm
    import mscmp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   go,
    input  logic   zero_skip,
    input  logic   req_ready,
    input  logic   rsp_valid,
    input  logic   last_iter,
    output state_e state
);
    state_e nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (go)        nxt = zero_skip ? ST_FIN : ST_RD1;
            ST_RD1:  if (req_ready) nxt = ST_WT1;
            ST_WT1:  if (rsp_valid) nxt = ST_RD2;
            ST_RD2:  if (req_ready) nxt = ST_WT2;
            ST_WT2:  if (rsp_valid) nxt = ST_EXEC;
            ST_EXEC: nxt = last_iter ? ST_FIN : ST_RD1;
            ST_FIN:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/mscmp_top.sv
`timescale 1ns/1ps
module mscmp_top
    import mscmp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic              size32,
    input  logic              addr32,
    input  logic              dir,
    input  logic              rep_en,
    input  logic [ADDR_W-1:0] si_in,
    input  logic [ADDR_W-1:0] di_in,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [1:0]        mem_req_size,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] si_out,
    output logic [ADDR_W-1:0] di_out,
    output logic [CNT_W-1:0]  cnt_out,
    output logic [5:0]        flags_out
);
    localparam int SHORT_W = 16;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    state_e            state_q;
    opsz_e             sz_q, sz_d;
    logic              dir_q, mode32_q, rep_q;
    logic [ADDR_W-1:0] ptr_q   [2];
    logic [ADDR_W-1:0] ptr_nx  [2];
    logic [CNT_W-1:0]  cnt_q;
    logic [31:0]       op1_q, op2_q;
    flags_t            flags_q, flags_new;
    logic              go, zero_skip, last_iter, opc_ok;
    logic [ADDR_W-1:0] cur_ptr;

    assign opc_ok    = (opcode == OPC_BYTE) || (opcode == OPC_WIDE);
    assign go        = start && opc_ok && (state_q == ST_IDLE);
    assign zero_skip = rep_en && (cnt_in == '0);
    assign last_iter = !rep_q || (cnt_q == CNT_ONE);
    assign sz_d      = (opcode == OPC_BYTE) ? SZ_BYTE : (size32 ? SZ_DWORD : SZ_WORD);

    mscmp_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .zero_skip (zero_skip),
        .req_ready (mem_req_ready),
        .rsp_valid (mem_rsp_valid),
        .last_iter (last_iter),
        .state     (state_q)
    );

    mscmp_alu alu_i (
        .op_a  (op1_q),
        .op_b  (op2_q),
        .sz    (sz_q),
        .flags (flags_new)
    );

    // one stepper per pointer: index 0 source, index 1 destination
    for (genvar g = 0; g < 2; g++) begin : g_step
        mscmp_step #(.ADDR_W(ADDR_W)) step_i (
            .ptr  (ptr_q[g]),
            .sz   (sz_q),
            .down (dir_q),
            .wide (mode32_q),
            .nxt  (ptr_nx[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sz_q     <= SZ_BYTE;
            dir_q    <= 1'b0;
            mode32_q <= 1'b0;
            rep_q    <= 1'b0;
            ptr_q[0] <= '0;
            ptr_q[1] <= '0;
            cnt_q    <= '0;
            op1_q    <= '0;
            op2_q    <= '0;
            flags_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (go) begin
                    sz_q     <= sz_d;
                    dir_q    <= dir;
                    mode32_q <= addr32;
                    rep_q    <= rep_en;
                    ptr_q[0] <= si_in;
                    ptr_q[1] <= di_in;
                    cnt_q    <= cnt_in;
                end
                ST_WT1: if (mem_rsp_valid) op1_q <= mem_rsp_data;
                ST_WT2: if (mem_rsp_valid) op2_q <= mem_rsp_data;
                ST_EXEC: begin
                    flags_q  <= flags_new;
                    ptr_q[0] <= ptr_nx[0];
                    ptr_q[1] <= ptr_nx[1];
                    if (rep_q) cnt_q <= cnt_q - CNT_ONE;
                end
                default: ;
            endcase
        end
    end

    assign cur_ptr       = (state_q == ST_RD2) ? ptr_q[1] : ptr_q[0];
    assign mem_req_valid = (state_q == ST_RD1) || (state_q == ST_RD2);
    assign mem_req_addr  = mode32_q ? cur_ptr
                                    : {{(ADDR_W-SHORT_W){1'b0}}, cur_ptr[SHORT_W-1:0]};
    assign mem_req_size  = sz_q;
    assign busy          = (state_q != ST_IDLE);
    assign done          = (state_q == ST_FIN);
    assign si_out        = ptr_q[0];
    assign di_out        = ptr_q[1];
    assign cnt_out       = cnt_q;
    assign flags_out     = flags_q;
endmodule

// File: rtl/mscmp_chk.sv
`timescale 1ns/1ps
module mscmp_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [7:0]        opcode,
    input logic              busy,
    input logic              done,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mode32_q
);
    // R10: completion pulse lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: done only while busy, no request while idle
    p_done_busy_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req_valid);

    // R7: request held steady under back-pressure
    p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R6: short address mode drives zero upper address bits
    p_short_addr_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mode32_q) |-> (mem_req_addr[ADDR_W-1:16] == '0));

    // R1: unknown opcode does not launch
    p_bad_opc_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && opcode != 8'hA6 && opcode != 8'hA7) |=> !busy);
endmodule

bind mscmp_top mscmp_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .opcode        (opcode),
    .busy          (busy),
    .done          (done),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mode32_q      (mode32_q)
);

// File: tb/mscmp_top_tb_top.sv
`timescale 1ns/1ps
module mscmp_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic        size32 = 1'b0, addr32 = 1'b0, dir = 1'b0, rep_en = 1'b0;
    logic [31:0] si_in = '0, di_in = '0, cnt_in = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic [1:0]  mem_req_size;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        busy, done;
    logic [31:0] si_out, di_out, cnt_out;
    logic [5:0]  flags_out;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    mscmp_top dut_i (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .size32(size32),
        .addr32(addr32), .dir(dir), .rep_en(rep_en), .si_in(si_in), .di_in(di_in),
        .cnt_in(cnt_in), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .busy(busy),
        .done(done), .si_out(si_out), .di_out(di_out), .cnt_out(cnt_out),
        .flags_out(flags_out)
    );

    // ---------------- memory model ----------------
    logic [7:0]  mem [0:255];
    logic [31:0] acc_addr [0:63];
    logic [1:0]  acc_size [0:63];
    int          acc_n = 0;
    logic        acc = 1'b0, pend = 1'b0;
    logic [31:0] paddr = '0;
    int          delay = 0;

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        return {mem[8'(a + 32'd3)], mem[8'(a + 32'd2)], mem[8'(a + 32'd1)], mem[8'(a)]};
    endfunction

    initial begin
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (acc) begin
                pend  = 1'b1;
                delay = int'($urandom % 3);
                acc   = 1'b0;
            end
            if (pend) begin
                if (delay == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd_word(paddr);
                    pend          = 1'b0;
                end else begin
                    delay = delay - 1;
                end
            end
            mem_req_ready = !pend && !mem_rsp_valid && ($urandom % 4 != 0);
            #2;
            acc = mem_req_valid && mem_req_ready;
            if (acc) begin
                paddr = mem_req_addr;
                if (acc_n < 64) begin
                    acc_addr[acc_n] = mem_req_addr;
                    acc_size[acc_n] = mem_req_size;
                end
                acc_n = acc_n + 1;
            end
        end
    end

    // ---------------- reference functions ----------------
    function automatic logic [5:0] ref_flags(input logic [31:0] a, input logic [31:0] b,
                                             input logic [1:0] sz);
        int unsigned w;
        longint unsigned m, ua, ub, r;
        logic sa, sb, sr, cf, of, sf, zf, af, pf;
        w  = (sz == 2'd0) ? 8 : ((sz == 2'd1) ? 16 : 32);
        m  = (64'd1 << w) - 64'd1;
        ua = {32'd0, a} & m;
        ub = {32'd0, b} & m;
        r  = (ua - ub) & m;
        sa = ua[w-1];
        sb = ub[w-1];
        sr = r[w-1];
        cf = ua < ub;
        of = (sa != sb) && (sr != sa);
        sf = sr;
        zf = (r == 0);
        af = (a[3:0] < b[3:0]);
        pf = ~^r[7:0];
        return {of, sf, zf, af, pf, cf};
    endfunction

    function automatic logic [31:0] eff_addr(input logic [31:0] p, input logic a32);
        return a32 ? p : {16'd0, p[15:0]};
    endfunction

    function automatic logic [31:0] adv(input logic [31:0] p, input logic [1:0] sz,
                                        input logic dn, input logic a32);
        logic [31:0] s, n;
        s = 32'd1 << sz;
        n = dn ? p - s : p + s;
        return a32 ? n : {p[31:16], n[15:0]};
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    logic [5:0]  exp_flags = '0;
    logic [31:0] exp_si = '0, exp_di = '0, exp_cnt = '0;

    task automatic run_case(input string tag, input logic [7:0] opc, input logic s32,
                            input logic a32, input logic dn, input logic rp,
                            input logic [31:0] si, input logic [31:0] di,
                            input logic [31:0] cnt);
        logic        ok;
        logic [1:0]  sz;
        int          n, t, seen;
        logic [31:0] s, d, ce;
        logic [5:0]  f;
        ok = (opc == 8'hA6) || (opc == 8'hA7);
        sz = (opc == 8'hA6) ? 2'd0 : (s32 ? 2'd2 : 2'd1);
        n  = rp ? int'(cnt) : 1;
        s  = si; d = di; f = exp_flags;
        for (int i = 0; i < n; i++) begin
            f = ref_flags(rd_word(eff_addr(s, a32)), rd_word(eff_addr(d, a32)), sz);
            s = adv(s, sz, dn, a32);
            d = adv(d, sz, dn, a32);
        end
        ce = rp ? 32'd0 : cnt;

        @(negedge clk);
        opcode = opc; size32 = s32; addr32 = a32; dir = dn; rep_en = rp;
        si_in = si; di_in = di; cnt_in = cnt; start = 1'b1;
        acc_n = 0;
        @(negedge clk);
        start = 1'b0;

        if (!ok) begin
            chk({tag, " R1 busy after bad opcode"}, {31'd0, busy}, 32'd0);
            seen = 0;
            for (int k = 0; k < 4; k++) begin
                if (done) seen++;
                @(negedge clk);
            end
            chk({tag, " R1 no done"}, seen, 0);
            chk({tag, " R1 no request"}, acc_n, 0);
            chk({tag, " R1 si kept"}, si_out, exp_si);
            chk({tag, " R1 di kept"}, di_out, exp_di);
            chk({tag, " R1 cnt kept"}, cnt_out, exp_cnt);
            chk({tag, " R1 flags kept"}, {26'd0, flags_out}, {26'd0, exp_flags});
            return;
        end

        chk({tag, " R10 busy"}, {31'd0, busy}, 32'd1);
        t = 0;
        while (!done && t < 500) begin
            @(negedge clk);
            t++;
        end
        if (t >= 500) begin
            checks++; fails++;
            $display("FAIL %s R10 done timeout actual=none expected=pulse", tag);
            return;
        end
        chk({tag, " R5 si"}, si_out, s);
        chk({tag, " R5 di"}, di_out, d);
        chk({tag, " R8 cnt"}, cnt_out, ce);
        chk({tag, " R3 flags"}, {26'd0, flags_out}, {26'd0, f});
        chk({tag, " R7 read count"}, acc_n, 2 * n);
        if (n > 0) begin
            chk({tag, " R2 src addr"}, acc_addr[0], eff_addr(si, a32));
            chk({tag, " R2 dst addr"}, acc_addr[1], eff_addr(di, a32));
            chk({tag, " R2 size"}, {30'd0, acc_size[0]}, {30'd0, sz});
        end
        @(negedge clk);
        chk({tag, " R10 done one cycle"}, {31'd0, done}, 32'd0);
        chk({tag, " R10 idle"}, {31'd0, busy}, 32'd0);
        exp_flags = f; exp_si = s; exp_di = d; exp_cnt = ce;
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset busy", {31'd0, busy}, 32'd0);
        chk("R10 reset done", {31'd0, done}, 32'd0);
        chk("R3 reset flags", {26'd0, flags_out}, 32'd0);
        chk("R5 reset si", si_out, 32'd0);

        // R3: equal bytes -> ZF and PF
        mem[8'h10] = 8'h55; mem[8'h20] = 8'h55;
        run_case("eq", 8'hA6, 0, 1, 0, 0, 32'h10, 32'h20, 32'd7);
        // R3/R4: 0x80-0x01 signed overflow, half borrow
        mem[8'h30] = 8'h80; mem[8'h40] = 8'h01;
        run_case("R4 ovf byte", 8'hA6, 0, 1, 0, 0, 32'h30, 32'h40, 32'd0);
        // R3: dword 0 - 1 -> borrow and sign
        for (int k = 0; k < 4; k++) begin mem[8'h50 + k] = 8'h00; mem[8'h60 + k] = 8'h00; end
        mem[8'h60] = 8'h01;
        run_case("borrow dword", 8'hA7, 1, 1, 1, 0, 32'h50, 32'h60, 32'd0);
        // R9: zero count keeps flags from the previous compare
        run_case("R9 zero count", 8'hA7, 0, 1, 0, 1, 32'h100, 32'h200, 32'd0);
        // R6: short address wrap upward and downward
        run_case("R6 wrap up", 8'hA7, 0, 0, 0, 0, 32'h1234_FFFF, 32'hABCD_FFFE, 32'd3);
        run_case("R6 wrap down", 8'hA6, 0, 0, 1, 0, 32'hABCD_0000, 32'h0000_0000, 32'd3);
        run_case("R6 dword wrap", 8'hA7, 1, 0, 0, 1, 32'h7777_FFFE, 32'h1111_FFFC, 32'd3);
        // R8: repeated word compares
        run_case("R8 rep5", 8'hA7, 0, 1, 0, 1, 32'h20, 32'h80, 32'd5);
        // R1: unknown opcode ignored
        run_case("R1 bad opc", 8'h90, 0, 1, 0, 0, 32'h999, 32'h888, 32'd2);

        for (int r = 0; r < 80; r++) begin
            logic [7:0] opc;
            logic       rp;
            logic [31:0] cn;
            opc = ($urandom % 10 == 0) ? 8'($urandom) : (($urandom % 2 == 0) ? 8'hA6 : 8'hA7);
            rp  = ($urandom % 3 == 0);
            cn  = rp ? ($urandom % 5) : $urandom;
            run_case("rand", opc, 1'($urandom), 1'($urandom), 1'($urandom), rp,
                     $urandom, $urandom, cn);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule